// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register front end of a multi-channel event timer. It decodes 32-bit reads and writes inside a 1 KiB address window. It owns a 64-bit main counter that advances on a tick strobe, a read-only capability word, a two-bit global configuration register and a status view of the channel interrupt flags. Accesses that fall in the channel area are passed on to per-channel sub-blocks, which return read data and report whether their comparator holds the all-ones value.

Software starts and stops the counter with the enable bit. The block acts only on changes of that bit. A rising edge re-arms every channel whose comparator is not all ones, and a falling edge freezes the counter and cancels all channels. A second configuration bit hands interrupt routing over from the legacy interval timer. Its changes produce one-cycle requests to disable or restore that timer. After every reset except the one that follows power-up, the block also requests that the legacy timer be restored. Channels read `main_count` directly for their comparisons.

Top module: `et_front`

## Requirements
- R1: Offset 0x000 reads the capability word 0x8086A201 (bits 12:8 hold the channel count minus one, bit 13 flags a 64-bit counter, bit 15 flags legacy routing). Offset 0x004 reads the tick period in femtoseconds. Writes to either offset leave both read values unchanged.
- R2: Offset 0x010 holds the configuration: bit 0 is enable and bit 1 is legacy routing. All other bits read zero. Offset 0x014 reads zero, and writes to it are ignored.
- R3: Offset 0x020 returns `chan_irq` in bits NUM_CH-1:0 and zero above. Writes to it have no effect.
- R4: `main_count` increments by one, carrying across the 32-bit halves, at each clock edge where `tick` is high and enable was set before the edge. Otherwise it holds its value.
- R5: Offsets 0x0F0 and 0x0F4 read and write the low and high counter halves independently, whether the counter is running or halted. A write to either half replaces that half and suppresses the increment in that cycle.
- R6: A write that changes enable from 0 to 1 raises `chan_arm[i]` for one cycle after the edge, for each channel i whose `chan_cmp_max[i]` is low. A write that changes enable from 1 to 0 raises `chan_cancel` for one cycle. Rewriting the same value raises neither.
- R7: A write that changes the legacy bit from 0 to 1 raises `pit_disable` for one cycle. A change from 1 to 0 raises `pit_enable` for one cycle.
- R8: Reset clears the counter and configuration. After a reset that accompanies `por_n`, `pit_enable` stays low. After any later reset, `pit_enable` is high from release until the first clock edge.
- R9: An access to 0x100 + 0x20*n with n < NUM_CH drives a one-hot `chan_sel` with bit n set and `chan_off` = addr[4:0]. It also forwards `bus_wr` on `chan_we` and `wdata` on `chan_wdata`, and a read returns that channel's 32-bit slice of `chan_rdata`.
- R10: Channel indices of NUM_CH and above, and undecoded offsets below 0x100, read zero and assert no `chan_sel` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick | input | 1 | Counter advance strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; `rdata` is zero when low |
| addr | input | 10 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| main_count | output | 64 | Main counter value |
| chan_sel | output | NUM_CH | One-hot channel access select |
| chan_we | output | 1 | Channel write strobe |
| chan_off | output | 5 | Register offset inside the channel |
| chan_wdata | output | 32 | Write data to channels |
| chan_rdata | input | 32*NUM_CH | Read data from channels, channel 0 lowest |
| chan_cmp_max | input | NUM_CH | Channel comparator holds all ones |
| chan_irq | input | NUM_CH | Channel interrupt flags |
| chan_arm | output | NUM_CH | One-cycle re-arm request per channel |
| chan_cancel | output | 1 | One-cycle cancel request to all channels |
| pit_disable | output | 1 | One-cycle request to turn off the legacy timer |
| pit_enable | output | 1 | One-cycle request to restore the legacy timer |

## Verification
The hardest case to reach is the difference between the first reset after power-up and every later reset. Only the later ones may raise `pit_enable`, and the pulse is visible only between reset release and the first clock edge. The stimulus therefore applies `por_n` and `rst_n` together at the start, checks just after release that `pit_enable` stays low, and near the end applies `rst_n` alone and samples `pit_enable` before the next edge. The counter carry across the 32-bit halves is reached by loading both halves just below the boundary while halted, then ticking after enable. Random counter writes, tick patterns, configuration toggles and comparator flags are checked against a bench model of the counter and of the edge pulses.

// File: rtl/et_pkg.sv
package et_pkg;
    localparam int unsigned ADDR_W = 10;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 2 * DATA_W;
    localparam int unsigned IDX_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG_LO = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_CFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
    localparam logic [ADDR_W-1:0] CH_BASE    = 10'h100;

    typedef enum logic [3:0] {
        RG_NONE, RG_CAP_LO, RG_CAP_HI, RG_CFG_LO, RG_CFG_HI,
        RG_STAT, RG_CNT_LO, RG_CNT_HI, RG_CHAN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] ch_idx;
    } dec_t;

    typedef struct packed {
        logic en;
        logic leg;
        logic cancel;
        logic pit_off;
        logic pit_on;
        logic boot;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, leg: 1'b0, cancel: 1'b0,
                                   pit_off: 1'b0, pit_on: 1'b0, boot: 1'b1};
endpackage

// File: rtl/et_decode.sv
module et_decode
    import et_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic              ch_hit
);
    always_comb begin
        dec = '{sel: RG_NONE, ch_idx: '0};
        if (addr >= CH_BASE) begin
            dec.sel    = RG_CHAN;
            dec.ch_idx = addr[ADDR_W-1:5] - IDX_W'(CH_BASE >> 5);
        end else begin
            unique case (addr)
                OFS_CAP_LO: dec.sel = RG_CAP_LO;
                OFS_CAP_HI: dec.sel = RG_CAP_HI;
                OFS_CFG_LO: dec.sel = RG_CFG_LO;
                OFS_CFG_HI: dec.sel = RG_CFG_HI;
                OFS_STAT:   dec.sel = RG_STAT;
                OFS_CNT_LO: dec.sel = RG_CNT_LO;
                OFS_CNT_HI: dec.sel = RG_CNT_HI;
                default:    dec.sel = RG_NONE;
            endcase
        end
    end

    assign ch_hit = (dec.sel == RG_CHAN) && (int'(dec.ch_idx) < int'(NUM_CH));
endmodule

// File: rtl/et_counter.sv
module et_counter
    import et_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d[DATA_W-1:0] = wdata;
        end else if (wr_hi) begin
            cnt_d[CNT_W-1:DATA_W] = wdata;
        end else if (run && tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/et_global_ctrl.sv
module et_global_ctrl
    import et_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    input  logic [NUM_CH-1:0] cmp_max,
    output logic              en,
    output logic              leg,
    output logic [NUM_CH-1:0] arm,
    output logic              cancel,
    output logic              pit_off,
    output logic              pit_on
);
    ctrl_t             s_d, s_q;
    logic [NUM_CH-1:0] arm_d, arm_q;
    logic              seen_q;

    always_comb begin
        s_d         = s_q;
        s_d.boot    = 1'b0;
        s_d.cancel  = 1'b0;
        s_d.pit_off = 1'b0;
        s_d.pit_on  = 1'b0;
        arm_d       = '0;
        if (cfg_we) begin
            s_d.en  = cfg_wdata[0];
            s_d.leg = cfg_wdata[1];
            if (cfg_wdata[0] && !s_q.en) arm_d = ~cmp_max;
            s_d.cancel  = !cfg_wdata[0] && s_q.en;
            s_d.pit_off = cfg_wdata[1] && !s_q.leg;
            s_d.pit_on  = !cfg_wdata[1] && s_q.leg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= CTRL_RST;
            arm_q <= '0;
        end else begin
            s_q   <= s_d;
            arm_q <= arm_d;
        end
    end

    // Marks that the reset tied to power-up has completed once.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 seen_q <= 1'b0;
        else if (s_q.boot && rst_n) seen_q <= 1'b1;
    end

    assign en      = s_q.en;
    assign leg     = s_q.leg;
    assign arm     = arm_q;
    assign cancel  = s_q.cancel;
    assign pit_off = s_q.pit_off;
    assign pit_on  = s_q.pit_on || (s_q.boot && seen_q);
endmodule

// File: rtl/et_front.sv
module et_front
    import et_pkg::*;
#(
    parameter int unsigned      NUM_CH    = 3,
    parameter logic [15:0]      VENDOR_ID = 16'h8086,
    parameter logic [7:0]       REV_ID    = 8'h01,
    parameter logic [31:0]      PERIOD_FS = 32'd10_000_000
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [9:0]               addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic [63:0]              main_count,
    output logic [NUM_CH-1:0]        chan_sel,
    output logic                     chan_we,
    output logic [4:0]               chan_off,
    output logic [31:0]              chan_wdata,
    input  logic [32*NUM_CH-1:0]     chan_rdata,
    input  logic [NUM_CH-1:0]        chan_cmp_max,
    input  logic [NUM_CH-1:0]        chan_irq,
    output logic [NUM_CH-1:0]        chan_arm,
    output logic                     chan_cancel,
    output logic                     pit_disable,
    output logic                     pit_enable
);
    localparam logic [DATA_W-1:0] CAP_WORD =
        {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REV_ID};

    initial begin
        if (NUM_CH < 1 || NUM_CH > 24) $error("NUM_CH out of range");
    end

    dec_t              dec;
    logic              ch_hit;
    logic              glb_en, glb_leg;
    logic [DATA_W-1:0] stat_w, chan_rd_w, rd_mux;

    et_decode #(.NUM_CH(NUM_CH)) i_decode (
        .addr   (addr),
        .dec    (dec),
        .ch_hit (ch_hit)
    );

    et_counter i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glb_en),
        .tick  (tick),
        .wr_lo (bus_wr && dec.sel == RG_CNT_LO),
        .wr_hi (bus_wr && dec.sel == RG_CNT_HI),
        .wdata (wdata),
        .count (main_count)
    );

    et_global_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cfg_we    (bus_wr && dec.sel == RG_CFG_LO),
        .cfg_wdata (wdata[1:0]),
        .cmp_max   (chan_cmp_max),
        .en        (glb_en),
        .leg       (glb_leg),
        .arm       (chan_arm),
        .cancel    (chan_cancel),
        .pit_off   (pit_disable),
        .pit_on    (pit_enable)
    );

    // Channel steering: one select per implemented channel.
    always_comb begin
        chan_sel  = '0;
        chan_rd_w = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (ch_hit && dec.ch_idx == IDX_W'(i)) begin
                chan_sel[i] = bus_wr || bus_rd;
                chan_rd_w   = chan_rdata[i*32 +: 32];
            end
        end
    end

    assign chan_we    = bus_wr && ch_hit;
    assign chan_off   = addr[4:0];
    assign chan_wdata = wdata;

    always_comb begin
        stat_w             = '0;
        stat_w[NUM_CH-1:0] = chan_irq;
        unique case (dec.sel)
            RG_CAP_LO: rd_mux = CAP_WORD;
            RG_CAP_HI: rd_mux = PERIOD_FS;
            RG_CFG_LO: rd_mux = {30'd0, glb_leg, glb_en};
            RG_STAT:   rd_mux = stat_w;
            RG_CNT_LO: rd_mux = main_count[31:0];
            RG_CNT_HI: rd_mux = main_count[63:32];
            RG_CHAN:   rd_mux = chan_rd_w;
            default:   rd_mux = '0;
        endcase
    end

    assign rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/et_front_chk.sv
module et_front_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [9:0]        addr,
    input logic              tick,
    input logic              glb_en,
    input logic [63:0]       main_count,
    input logic [NUM_CH-1:0] chan_sel,
    input logic [NUM_CH-1:0] chan_arm,
    input logic              chan_cancel,
    input logic              pit_disable,
    input logic              pit_enable
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (addr[9:3] == 7'h1E);

    assert_arm_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_arm) |-> (glb_en && !$past(glb_en)));

    assert_cancel_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_cancel |-> (!glb_en && $past(glb_en)));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cnt_wr) |=> $stable(main_count));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && tick && !cnt_wr) |=> (main_count == $past(main_count) + 64'd1));

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    assert_no_sel_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < 10'h100) |-> (chan_sel == '0));

    assert_pit_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pit_disable && pit_enable));
endmodule

bind et_front et_front_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .addr        (addr),
    .tick        (tick),
    .glb_en      (glb_en),
    .main_count  (main_count),
    .chan_sel    (chan_sel),
    .chan_arm    (chan_arm),
    .chan_cancel (chan_cancel),
    .pit_disable (pit_disable),
    .pit_enable  (pit_enable)
);

// File: tb/test_et_front.sv
module test_et_front;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;

    logic             clk = 1'b0;
    logic             por_n, rst_n, tick, bus_wr, bus_rd;
    logic [9:0]       addr;
    logic [31:0]      wdata, rdata;
    logic [63:0]      main_count;
    logic [NCH-1:0]   chan_sel, chan_cmp_max, chan_irq, chan_arm;
    logic             chan_we, chan_cancel, pit_disable, pit_enable;
    logic [4:0]       chan_off;
    logic [31:0]      chan_wdata;
    logic [32*NCH-1:0] chan_rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [63:0]    m_cnt;
    logic           m_en, m_leg;
    logic [NCH-1:0] x_arm;
    logic           x_cancel, x_poff, x_pon;

    always #(CLK_PERIOD/2) clk = ~clk;

    et_front i_et_front (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .main_count(main_count), .chan_sel(chan_sel),
        .chan_we(chan_we), .chan_off(chan_off), .chan_wdata(chan_wdata),
        .chan_rdata(chan_rdata), .chan_cmp_max(chan_cmp_max),
        .chan_irq(chan_irq), .chan_arm(chan_arm), .chan_cancel(chan_cancel),
        .pit_disable(pit_disable), .pit_enable(pit_enable)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        addr = a; bus_rd = 1'b1;
        #1 v = rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {32'd0, v}, {32'd0, exp});
    endtask

    // One clock cycle with an optional write and tick; updates the model.
    task automatic cyc(input bit wr, input logic [9:0] a, input logic [31:0] d, input bit tk);
        bus_wr = wr; addr = a; wdata = d; tick = tk;
        x_arm = '0; x_cancel = 0; x_poff = 0; x_pon = 0;
        @(posedge clk);
        if (wr && a == 10'h0F0)      m_cnt[31:0]  = d;
        else if (wr && a == 10'h0F4) m_cnt[63:32] = d;
        else if (m_en && tk)         m_cnt        = m_cnt + 64'd1;
        if (wr && a == 10'h010) begin
            if (d[0] && !m_en) x_arm = ~chan_cmp_max;
            x_cancel = !d[0] && m_en;
            x_poff   = d[1] && !m_leg;
            x_pon    = !d[1] && m_leg;
            m_en = d[0]; m_leg = d[1];
        end
        @(negedge clk);
        bus_wr = 0; tick = 0;
    endtask

    task automatic pulse_chk(input string tag);
        chk({tag, " arm"},    {61'd0, chan_arm},    {61'd0, x_arm});
        chk({tag, " cancel"}, {63'd0, chan_cancel}, {63'd0, x_cancel});
        chk({tag, " pitoff"}, {63'd0, pit_disable}, {63'd0, x_poff});
        chk({tag, " piton"},  {63'd0, pit_enable},  {63'd0, x_pon});
    endtask

    task automatic cnt_chk(input string tag);
        rd_chk({tag, " cnt lo"}, 10'h0F0, m_cnt[31:0]);
        rd_chk({tag, " cnt hi"}, 10'h0F4, m_cnt[63:32]);
        chk({tag, " main_count"}, main_count, m_cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        por_n = 0; rst_n = 0; tick = 0; bus_wr = 0; bus_rd = 0;
        addr = '0; wdata = '0; chan_cmp_max = '0; chan_irq = '0;
        chan_rdata = {32'hCAFE0002, 32'hCAFE0001, 32'hCAFE0000};
        m_cnt = '0; m_en = 0; m_leg = 0;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        #1 chk("R8 no restore after power-up reset", {63'd0, pit_enable}, 64'd0);
        @(negedge clk);
        chk("R8 pit_enable stays low", {63'd0, pit_enable}, 64'd0);
        cnt_chk("R8 reset");
        rd_chk("R8 cfg reset", 10'h010, 32'd0);

        // R1 capability
        rd_chk("R1 cap lo", 10'h000, 32'h8086A201);
        rd_chk("R1 cap hi", 10'h004, 32'd10_000_000);
        cyc(1, 10'h000, 32'hFFFF_FFFF, 0);
        cyc(1, 10'h004, 32'h1234_5678, 0);
        rd_chk("R1 cap lo after write", 10'h000, 32'h8086A201);
        rd_chk("R1 cap hi after write", 10'h004, 32'd10_000_000);

        // R2 configuration
        cyc(1, 10'h010, 32'hFFFF_FFFC, 0);
        rd_chk("R2 cfg reserved bits", 10'h010, 32'd0);
        cyc(1, 10'h014, 32'hFFFF_FFFF, 0);
        rd_chk("R2 cfg hi", 10'h014, 32'd0);
        rd_chk("R2 cfg lo after hi write", 10'h010, 32'd0);

        // R3 status
        chan_irq = 3'b101;
        rd_chk("R3 status", 10'h020, 32'd5);
        cyc(1, 10'h020, 32'hFFFF_FFFF, 0);
        rd_chk("R3 status after write", 10'h020, 32'd5);
        chan_irq = 3'b010;
        rd_chk("R3 status follows", 10'h020, 32'd2);

        // R9 channel forwarding
        bus_wr = 1; addr = 10'h128; wdata = 32'h0BAD_F00D;
        #1;
        chk("R9 sel",   {61'd0, chan_sel},   64'b010);
        chk("R9 we",    {63'd0, chan_we},    64'd1);
        chk("R9 off",   {59'd0, chan_off},   64'd8);
        chk("R9 wdata", {32'd0, chan_wdata}, 64'h0BAD_F00D);
        @(posedge clk); @(negedge clk); bus_wr = 0;
        rd_chk("R9 read ch2", 10'h140, 32'hCAFE0002);
        rd_chk("R9 read ch0", 10'h10C, 32'hCAFE0000);

        // R10 out of range
        addr = 10'h164; bus_rd = 1; bus_wr = 1;
        #1 chk("R10 no sel idx3", {61'd0, chan_sel}, 64'd0);
        chk("R10 read idx3", {32'd0, rdata}, 64'd0);
        bus_wr = 0; bus_rd = 0;
        rd_chk("R10 read idx7", 10'h3E0, 32'd0);
        rd_chk("R10 undecoded", 10'h030, 32'd0);

        // R4/R5 halted counter, halves, carry
        cyc(0, 10'h000, 0, 1); cyc(0, 10'h000, 0, 1);
        cnt_chk("R4 halted ticks");
        cyc(1, 10'h0F0, 32'hFFFF_FFFE, 1);
        cyc(1, 10'h0F4, 32'h0000_0001, 1);
        cnt_chk("R5 halted writes");

        // R6 enable rise with comparator flags
        chan_cmp_max = 3'b010;
        cyc(1, 10'h010, 32'h1, 0);
        pulse_chk("R6 rise");
        chk("R6 arm value", {61'd0, chan_arm}, 64'b101);
        cyc(0, 10'h000, 0, 1);
        chk("R6 arm one cycle", {61'd0, chan_arm}, 64'd0);
        cyc(0, 10'h000, 0, 1); cyc(0, 10'h000, 0, 1);
        cnt_chk("R4 carry");
        chk("R4 carry value", main_count, 64'h2_0000_0001);
        cyc(1, 10'h010, 32'h1, 0);
        pulse_chk("R6 same value");

        // R5 write beats tick while running
        cyc(1, 10'h0F0, 32'h0000_0100, 1);
        cnt_chk("R5 write over tick");
        cyc(1, 10'h010, 32'h0, 1);
        pulse_chk("R6 fall");
        chk("R6 cancel", {63'd0, chan_cancel}, 64'd1);

        // R7 legacy bit
        cyc(1, 10'h010, 32'h2, 0);
        pulse_chk("R7 legacy rise");
        chk("R7 pit_disable", {63'd0, pit_disable}, 64'd1);
        cyc(1, 10'h010, 32'h0, 0);
        pulse_chk("R7 legacy fall");
        chk("R7 pit_enable", {63'd0, pit_enable}, 64'd1);

        // Random mix: R4 R5 R6 R7
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 7);
            chan_cmp_max = 3'($urandom);
            case (op)
                0: cyc(1, 10'h0F0, $urandom, $urandom % 2 == 0);
                1: cyc(1, 10'h0F4, $urandom % 4, $urandom % 2 == 0);
                2: cyc(1, 10'h010, $urandom % 4, $urandom % 2 == 0);
                default: cyc(0, 10'h020, 0, $urandom % 3 != 0);
            endcase
            pulse_chk("R6 R7 random");
            cnt_chk("R4 R5 random");
        end

        // R8 later reset
        cyc(1, 10'h010, 32'h3, 1);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1; m_cnt = '0; m_en = 0; m_leg = 0;
        #1 chk("R8 restore after later reset", {63'd0, pit_enable}, 64'd1);
        @(negedge clk);
        chk("R8 restore one cycle", {63'd0, pit_enable}, 64'd0);
        cnt_chk("R8 later reset");
        rd_chk("R8 cfg cleared", 10'h010, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule